// File: doc/BRIEF.md
# Sticky Error Status Register with Clear-on-Read

This block collects error events into a 16-bit status word. Each of eight error strobes sets its own flag bit, and that bit stays set until software reads the word. The eight bits above the flags are always zero. While any flag is set, a terminal flag output is high. On the cycle the terminal flag goes high, the block emits a one-cycle pulse that the surrounding design uses to reset its bus interface logic.

A read strobe captures the current flags into a registered read-data output. In the same clock edge the read clears every flag. An error that arrives in the same cycle as a read is not returned by that read. It survives the clear and shows up in the next read. Which conditions count as errors, and what the reset pulse resets, are decided by the surrounding design.

Top module: `err_status_reg`

## Requirements
- R1: After a synchronous reset `rd_data_o` is 0000h, `term_flag_o` is 0 and `ifc_rst_o` is 0.
- R2: A high on `err_i[k]` in a cycle sets status bit k (bit k of the read word) at that clock edge. The bit stays set through any number of later cycles without a read, even after the strobe goes away.
- R3: Bits 15 to 8 of `rd_data_o` are always 0.
- R4: A read strobe in cycle t places the status held before edge t on `rd_data_o` after that edge. `rd_data_o` then holds that value until the next read.
- R5: A read with no concurrent error clears the whole status to 0000h, so an immediate second read returns 0000h.
- R6: When an error and a read happen in the same cycle, the read returns the status without the new bit. The new bit remains set after the clear.
- R7: `term_flag_o` is 1 in exactly those cycles in which at least one status bit is set. It rises on the edge after the first error strobe.
- R8: After a read that clears the status with no error in the same cycle, `term_flag_o` is 0 from the following edge onward, until a new error arrives.
- R9: `ifc_rst_o` is high for exactly one cycle, in the cycle where `term_flag_o` goes from 0 to 1. It stays low while `term_flag_o` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 8 | Error strobes; bit k sets status bit k |
| rd_i | input | 1 | Read strobe; captures and clears the status |
| rd_data_o | output | 16 | Status word captured by the last read |
| term_flag_o | output | 1 | High while any status bit is set |
| ifc_rst_o | output | 1 | One-cycle interface reset pulse on rise of the terminal flag |

## Verification
The bench targets four corner cases:
- **Read colliding with an error.** A design that let the clear win would lose the error. A design that forwarded the error into the read would report it twice.
- **Error strobe removed long before the read.** A non-sticky design would return zero here.
- **Read that clears the status.** A flag wired as a level from the last strobe would not drop after the read. An interface reset wired as a level would stay high while the flag is held.
- **Repeated rising flag after a clear.** A design whose pulse fired only once would miss the second rise.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int STAT_W_DEF = 16;
  localparam int ERR_W_DEF  = 8;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_i,
  input  logic             rd_i,
  output logic [ERR_W-1:0] flags_q,
  output logic [ERR_W-1:0] flags_nxt
);
  for (genvar g = 0; g < ERR_W; g++) begin : g_bit
    assign flags_nxt[g] = (flags_q[g] & ~rd_i) | err_i[g];
    always_ff @(posedge clk) begin
      if (rst) flags_q[g] <= 1'b0;
      else     flags_q[g] <= flags_nxt[g];
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      err_i[g] |=> flags_q[g]);
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && err_i == '0) |=> (flags_q == '0));
endmodule

// File: rtl/err_read_port.sv
module err_read_port #(
  parameter int STAT_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ERR_W-1:0]  flags_q,
  output logic [STAT_W-1:0] rd_data_o
);
  localparam int PAD_W = STAT_W - ERR_W;

  always_ff @(posedge clk) begin
    if (rst)       rd_data_o <= '0;
    else if (rd_i) rd_data_o <= {{PAD_W{1'b0}}, flags_q};
  end

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[STAT_W-1:ERR_W] == '0);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: rtl/err_term_ctrl.sv
module err_term_ctrl #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] flags_q,
  input  logic [ERR_W-1:0] flags_nxt,
  output logic             term_flag_o,
  output logic             ifc_rst_o
);
  logic any_nxt;
  assign any_nxt = |flags_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      term_flag_o <= 1'b0;
      ifc_rst_o   <= 1'b0;
    end else begin
      term_flag_o <= any_nxt;
      ifc_rst_o   <= any_nxt & ~term_flag_o;
    end
  end

  assert_term_R7: assert property (@(posedge clk) disable iff (rst)
    term_flag_o == (flags_q != '0));
  assert_rise_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(term_flag_o) |-> ifc_rst_o);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ifc_rst_o |=> !ifc_rst_o);
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
#(
  parameter int STAT_W = STAT_W_DEF,
  parameter int ERR_W  = ERR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              term_flag_o,
  output logic              ifc_rst_o
);
  logic [ERR_W-1:0] flags_q;
  logic [ERR_W-1:0] flags_nxt;

  err_flag_bank #(.ERR_W(ERR_W)) u_bank (
    .clk(clk), .rst(rst), .err_i(err_i), .rd_i(rd_i),
    .flags_q(flags_q), .flags_nxt(flags_nxt)
  );

  err_read_port #(.STAT_W(STAT_W), .ERR_W(ERR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_i), .flags_q(flags_q),
    .rd_data_o(rd_data_o)
  );

  err_term_ctrl #(.ERR_W(ERR_W)) u_term (
    .clk(clk), .rst(rst), .flags_q(flags_q), .flags_nxt(flags_nxt),
    .term_flag_o(term_flag_o), .ifc_rst_o(ifc_rst_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data_o == '0 && !term_flag_o && !ifc_rst_o));
endmodule

// File: tb/err_status_reg_tb.sv
module err_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  err_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        term_flag_o;
  logic        ifc_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;

  int exp_flags = 0;
  int exp_rd = 0;
  bit exp_term = 0;
  bit exp_pulse = 0;

  always #2 clk = ~clk;

  err_status_reg dut_i (
    .clk(clk), .rst(rst), .err_i(err_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .term_flag_o(term_flag_o), .ifc_rst_o(ifc_rst_o)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      exp_flags = 0; exp_rd = 0; exp_term = 0; exp_pulse = 0;
    end else begin
      if (rd_i) exp_rd = exp_flags;
      exp_flags = (rd_i ? 0 : exp_flags) | int'(err_i);
      exp_pulse = (exp_flags != 0) && !exp_term;
      exp_term  = (exp_flags != 0);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 rd_data model", int'(rd_data_o), exp_rd);
      check("R7 term model", int'(term_flag_o), int'(exp_term));
      check("R9 pulse model", int'(ifc_rst_o), int'(exp_pulse));
      if (ifc_rst_o) pulses++;
    end
  end

  task automatic cyc(logic [7:0] e, logic r);
    @(negedge clk);
    #1;
    err_i = e;
    rd_i  = r;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rd_data", int'(rd_data_o), 0);
        check("R1 term", int'(term_flag_o), 0);
        check("R1 ifc_rst", int'(ifc_rst_o), 0);
        #1 rst = 1'b0;

        // R2 sticky bit after strobe removed
        cyc(8'h08, 1'b0);
        idle(1);
        check("R7 term high", int'(term_flag_o), 1);
        check("R9 pulse on rise", int'(ifc_rst_o), 1);
        idle(5);
        check("R9 no pulse while high", int'(ifc_rst_o), 0);
        cyc(8'h00, 1'b1);
        cyc(8'h00, 1'b0);
        check("R2 sticky read", int'(rd_data_o), 16'h0008);
        check("R8 term cleared", int'(term_flag_o), 0);
        idle(3);
        check("R8 term stays low", int'(term_flag_o), 0);
        check("R4 data held", int'(rd_data_o), 16'h0008);

        // R3 all flags, upper byte zero
        cyc(8'hFF, 1'b0);
        cyc(8'h00, 1'b1);
        cyc(8'h00, 1'b0);
        check("R3 upper zero", int'(rd_data_o), 16'h00FF);
        cyc(8'h00, 1'b1);
        cyc(8'h00, 1'b0);
        check("R5 second read zero", int'(rd_data_o), 0);

        // R6 collision of read and error
        cyc(8'h02, 1'b0);
        cyc(8'h20, 1'b1);
        cyc(8'h00, 1'b0);
        check("R6 read returns old", int'(rd_data_o), 16'h0002);
        check("R6 term kept", int'(term_flag_o), 1);
        cyc(8'h00, 1'b1);
        cyc(8'h00, 1'b0);
        check("R6 new bit kept", int'(rd_data_o), 16'h0020);

        // mixed pattern
        for (int i = 0; i < 40; i++)
          cyc(8'(1 << (i % 8)) & {8{i % 3 == 0}}, (i % 7) == 6);
        cyc(8'h00, 1'b1);
        idle(2);
        check("R9 pulses seen", int'(pulses > 2), 1);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule